// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block drives a single display DMA channel through a chain of frame descriptors held in memory. Each descriptor occupies four consecutive 32-bit words: the pointer to the next descriptor, the frame source address, a frame identifier and a command word. When a frame begins, the engine picks the address of the descriptor to load. A pending one-shot branch takes priority over the stored chain pointer. The engine then reads the descriptor one word at a time and holds its fields for the pixel mover that sits downstream.

The engine also emits the frame-boundary events: start of frame, end of frame, branch taken, bus error and last frame done. The command word decides whether start and end of frame are reported. A bad source address gives a bus error in place of a transfer. A pending stop request ends the channel at the close of the current frame.

Memory reads go through a request channel with valid/ready. The engine raises `mem_req_valid` with an address and holds both until a cycle where `mem_req_ready` is high. It then waits for exactly one `mem_rsp_valid` beat and accepts it unconditionally. Only one read is ever outstanding, so the response side needs no back-pressure.

Top module: `frame_desc_fetch`

## Requirements
- R1: After reset the channel is stopped and idle. No request is issued, all event outputs are low, and the branch, descriptor-pointer, source, ID and command registers read zero.
- R2: A software write to the descriptor pointer keeps bits 31:4 and clears bits 3:0. A next-pointer loaded from a descriptor is aligned to 16 bytes in the same way.
- R3: A software write to the branch register keeps only the bits under mask 0xFFFFFFF3. Bit 0 is the branch request, bit 1 is the branch interrupt and bits 31:4 hold the branch descriptor address.
- R4: At a frame start with branch bit 0 set, the descriptor address is {branch[31:4],4'b0}, bit 0 is cleared, and a branch event pulses when bit 1 is also set. With bit 0 clear, the stored pointer is used and no branch event pulses.
- R5: A descriptor is read as four single-word requests at A, A+4, A+8 and A+12, in that order. The words are latched as next-pointer, source, frame ID and command. A request holds its valid and address stable until it is accepted.
- R6: A descriptor at A is loaded only when WIN_BASE <= A and A+16 <= WIN_BASE+WIN_SIZE. If it is outside, no read is issued, the source is set to zero, and the pointer, ID and command keep their values.
- R7: If the source is zero or lies outside [WIN_BASE, WIN_BASE+WIN_SIZE), a bus-error event pulses and no transfer starts. Neither start-of-frame nor end-of-frame is reported for that frame.
- R8: When the source is valid, start-of-frame pulses together with `xfer_start` if command bit 22 is set. End-of-frame pulses after `xfer_done` if command bit 21 is set.
- R9: If `stop_req` is high when a frame ends, the channel stops running and a last-frame-done event pulses.
- R10: A frame start is ignored while the channel is stopped or a frame is already in progress.
- R11: A branch write during a frame changes nothing in that frame. It takes effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_wr | input | 1 | Write strobe for the run flag |
| run_val | input | 1 | Value written to the run flag |
| stop_req | input | 1 | Stop the channel at the end of the current frame |
| frame_start | input | 1 | Frame start pulse |
| br_wr | input | 1 | Branch register write strobe |
| br_wdata | input | 32 | Branch register write data |
| fd_wr | input | 1 | Descriptor pointer write strobe |
| fd_wdata | input | 32 | Descriptor pointer write data |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xfer_start | output | 1 | Pulse: start the frame transfer |
| xfer_done | input | 1 | Pulse: the frame transfer has finished |
| running | output | 1 | Channel enabled |
| busy | output | 1 | A frame is in progress |
| br_value | output | 32 | Branch register value |
| fd_addr | output | 32 | Stored next-descriptor pointer |
| src_addr | output | 32 | Latched frame source address |
| frame_id | output | 32 | Latched frame ID |
| command | output | 32 | Latched command word |
| sof_evt | output | 1 | Start-of-frame event pulse |
| eof_evt | output | 1 | End-of-frame event pulse |
| brs_evt | output | 1 | Branch-taken event pulse |
| ber_evt | output | 1 | Bus-error event pulse |
| lfd_evt | output | 1 | Last-frame-done event pulse |

## Verification
The bench covers the window edges for both descriptor and source addresses: the last 16-byte slot inside the window, the first slot outside it, a zero source and a source one word below the top. A design with an off-by-one compare would issue reads it should skip, or it would flag a bus error on a good frame. Branch tests run with and without the interrupt bit and include a branch write and a second frame start that land mid-fetch. A design that sampled the branch register late, or restarted while busy, would read the wrong address or issue extra reads. Random memory latency and random request back-pressure check that the read order and address hold are right. A wrong event order would show up as an end-of-frame before the transfer finishes.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_CHK,
    ST_XFER,
    ST_END
  } fdf_state_e;

  localparam int WORDS_PER_DESC = 4;
  localparam int DESC_BYTES     = 4 * WORDS_PER_DESC;
  localparam int BR_REQ_BIT     = 0;
  localparam int BR_INT_BIT     = 1;
  localparam int CMD_EOF_BIT    = 21;
  localparam int CMD_SOF_BIT    = 22;
endpackage

// File: rtl/frame_win_chk.sv
module frame_win_chk #(
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW:0]   SIZE = '0,
  parameter int            SPAN = 1
) (
  input  logic [AW-1:0] addr,
  output logic          ok
);
  localparam logic [AW:0] LO_L = {1'b0, BASE};
  localparam logic [AW:0] HI_L = {1'b0, BASE} + SIZE;
  localparam logic [AW:0] SPAN_L = (AW+1)'(SPAN);

  logic [AW:0] a_ext;
  assign a_ext = {1'b0, addr};
  assign ok = (a_ext >= LO_L) && ((a_ext + SPAN_L) <= HI_L);
endmodule

// File: rtl/frame_branch_reg.sv
module frame_branch_reg import fdf_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          consume,
  output logic [AW-1:0] q
);
  localparam logic [AW-1:0] KEEP_MASK = ~(AW'(4'b1100));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (wr_en)    q <= wr_data & KEEP_MASK;
    else if (consume)  q[BR_REQ_BIT] <= 1'b0;
  end

  // R4
  br_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !wr_en) |=> !q[BR_REQ_BIT]);
endmodule

// File: rtl/frame_desc_store.sv
module frame_desc_store import fdf_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_data,
  input  logic          ld_en,
  input  logic [1:0]    ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          zero_src,
  output logic [AW-1:0] next_ptr,
  output logic [AW-1:0] src,
  output logic [AW-1:0] id,
  output logic [AW-1:0] cmd
);
  localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(DESC_BYTES - 1));

  logic [AW-1:0] word_q [WORDS_PER_DESC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS_PER_DESC; k++) word_q[k] <= '0;
    end else begin
      for (int k = 0; k < WORDS_PER_DESC; k++) begin
        if (k == 0) begin
          if (sw_wr)                           word_q[k] <= sw_data & ALIGN_MASK;
          else if (ld_en && ld_idx == 2'(k))   word_q[k] <= ld_data & ALIGN_MASK;
        end else if (k == 1) begin
          if (zero_src)                        word_q[k] <= '0;
          else if (ld_en && ld_idx == 2'(k))   word_q[k] <= ld_data;
        end else begin
          if (ld_en && ld_idx == 2'(k))        word_q[k] <= ld_data;
        end
      end
    end
  end

  assign next_ptr = word_q[0];
  assign src      = word_q[1];
  assign id       = word_q[2];
  assign cmd      = word_q[3];
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch import fdf_pkg::*; #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] WIN_BASE = 'h4000_0000,
  parameter logic [AW:0]   WIN_SIZE = 'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_wr,
  input  logic          run_val,
  input  logic          stop_req,
  input  logic          frame_start,
  input  logic          br_wr,
  input  logic [AW-1:0] br_wdata,
  input  logic          fd_wr,
  input  logic [AW-1:0] fd_wdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          xfer_start,
  input  logic          xfer_done,
  output logic          running,
  output logic          busy,
  output logic [AW-1:0] br_value,
  output logic [AW-1:0] fd_addr,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] frame_id,
  output logic [AW-1:0] command,
  output logic          sof_evt,
  output logic          eof_evt,
  output logic          brs_evt,
  output logic          ber_evt,
  output logic          lfd_evt
);
  localparam int          IW     = $clog2(WORDS_PER_DESC);
  localparam logic [AW:0] WIN_HI = {1'b0, WIN_BASE} + WIN_SIZE;

  fdf_state_e    st_q;
  logic [IW-1:0] widx_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] sel_addr;
  logic          go, take_br, desc_ok, src_in_win, src_ok, ld_en;

  assign go       = (st_q == ST_IDLE) && frame_start && running;
  assign take_br  = br_value[BR_REQ_BIT];
  assign sel_addr = take_br ? {br_value[AW-1:4], 4'b0000} : fd_addr;
  assign ld_en    = (st_q == ST_RSP) && mem_rsp_valid;
  assign src_ok   = (src_addr != '0) && src_in_win;

  frame_branch_reg #(.AW(AW)) u_branch (
    .clk(clk), .rst_n(rst_n), .wr_en(br_wr), .wr_data(br_wdata),
    .consume(go && take_br), .q(br_value)
  );

  frame_desc_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .sw_wr(fd_wr), .sw_data(fd_wdata),
    .ld_en(ld_en), .ld_idx(widx_q), .ld_data(mem_rsp_data),
    .zero_src(go && !desc_ok),
    .next_ptr(fd_addr), .src(src_addr), .id(frame_id), .cmd(command)
  );

  frame_win_chk #(.AW(AW), .BASE(WIN_BASE), .SIZE(WIN_SIZE), .SPAN(DESC_BYTES))
    u_desc_win (.addr(sel_addr), .ok(desc_ok));

  frame_win_chk #(.AW(AW), .BASE(WIN_BASE), .SIZE(WIN_SIZE), .SPAN(1))
    u_src_win (.addr(src_addr), .ok(src_in_win));

  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = base_q + {{(AW-IW-2){1'b0}}, widx_q, 2'b00};
  assign busy          = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      widx_q     <= '0;
      base_q     <= '0;
      running    <= 1'b0;
      xfer_start <= 1'b0;
      sof_evt    <= 1'b0;
      eof_evt    <= 1'b0;
      brs_evt    <= 1'b0;
      ber_evt    <= 1'b0;
      lfd_evt    <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      sof_evt    <= 1'b0;
      eof_evt    <= 1'b0;
      brs_evt    <= 1'b0;
      ber_evt    <= 1'b0;
      lfd_evt    <= 1'b0;
      if (run_wr) running <= run_val;
      case (st_q)
        ST_IDLE: if (go) begin
          brs_evt <= take_br && br_value[BR_INT_BIT];
          base_q  <= sel_addr;
          widx_q  <= '0;
          st_q    <= desc_ok ? ST_REQ : ST_CHK;
        end
        ST_REQ: if (mem_req_ready) st_q <= ST_RSP;
        ST_RSP: if (mem_rsp_valid) begin
          if (widx_q == IW'(WORDS_PER_DESC - 1)) st_q <= ST_CHK;
          else begin
            widx_q <= widx_q + 1'b1;
            st_q   <= ST_REQ;
          end
        end
        ST_CHK: begin
          if (!src_ok) begin
            ber_evt <= 1'b1;
            st_q    <= ST_END;
          end else begin
            sof_evt    <= command[CMD_SOF_BIT];
            xfer_start <= 1'b1;
            st_q       <= ST_XFER;
          end
        end
        ST_XFER: if (xfer_done) begin
          eof_evt <= command[CMD_EOF_BIT];
          st_q    <= ST_END;
        end
        ST_END: begin
          if (stop_req) begin
            lfd_evt <= 1'b1;
            if (!run_wr) running <= 1'b0;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_addr >= WIN_BASE) && ({1'b0, mem_req_addr} < WIN_HI)));

  // R7
  xfer_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (src_addr != '0));

  // R9
  lfd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfd_evt |-> (!running || $past(run_wr)));

  // R8
  eof_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |-> $past(xfer_done));
endmodule

// File: tb/frame_desc_fetch_bench.sv
module frame_desc_fetch_bench;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [32:0] SIZE = 33'h0000_1000;
  localparam longint      LO   = longint'(BASE);
  localparam longint      HI   = longint'(BASE) + longint'(SIZE);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_wr = 0, run_val = 0, stop_req = 0, frame_start = 0;
  logic        br_wr = 0, fd_wr = 0;
  logic [31:0] br_wdata = '0, fd_wdata = '0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic        xfer_start, xfer_done = 0;
  logic        running, busy;
  logic [31:0] br_value, fd_addr, src_addr, frame_id, command;
  logic        sof_evt, eof_evt, brs_evt, ber_evt, lfd_evt;

  frame_desc_fetch u_frame_desc_fetch (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:1023];

  int c_sof, c_eof, c_brs, c_ber, c_lfd, c_xs, req_n;
  bit order_err, xdone_given;
  logic [31:0] exp_base;
  logic [31:0] m_br, m_fd, m_src, m_id, m_cmd;
  bit m_run;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit desc_in(input logic [31:0] a);
    return (longint'(a) >= LO) && (longint'(a) + 16 <= HI);
  endfunction

  function automatic bit src_good(input logic [31:0] s);
    return (s != 0) && (longint'(s) >= LO) && (longint'(s) < HI);
  endfunction

  function automatic logic [31:0] rnd_addr(input int out_pct);
    if (($urandom % 100) < out_pct)
      return (($urandom % 2) == 0) ? BASE + SIZE[31:0] + ($urandom % 512) : BASE - 32'd16 - ($urandom % 256);
    return BASE + ($urandom % SIZE[31:0]);
  endfunction

  function automatic logic [31:0] rnd_src();
    int r = $urandom % 6;
    if (r == 0) return 32'h0;
    if (r == 1) return rnd_addr(100);
    return rnd_addr(0);
  endfunction

  // memory responder: random ready, random latency, one outstanding
  initial begin
    bit hs = 0, pend = 0;
    int dly = 0;
    logic [31:0] hs_addr = '0, p_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs) begin
        chk("R5 request address order", hs_addr, exp_base + 32'(4 * req_n));
        req_n++;
        pend = 1; dly = $urandom % 3; p_addr = hs_addr;
      end
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[((p_addr - BASE) >> 2) & 32'h3FF];
          pend = 0;
        end else dly--;
      end
      mem_req_ready = (($urandom % 4) != 0);
      hs = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
    end
  end

  // transfer responder
  initial begin
    bit xp = 0;
    int xd = 0;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (xp) begin
        if (xd == 0) begin xfer_done = 1'b1; xdone_given = 1; xp = 0; end
        else xd--;
      end
      if (xfer_start) begin xp = 1; xd = $urandom % 4; end
    end
  end

  // event monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sof_evt) begin c_sof++; if (xdone_given) order_err = 1; end
      if (eof_evt) begin c_eof++; if (!xdone_given) order_err = 1; end
      if (brs_evt) c_brs++;
      if (ber_evt) c_ber++;
      if (lfd_evt) c_lfd++;
      if (xfer_start) c_xs++;
    end
  end

  task automatic write_fd(input logic [31:0] v);
    @(negedge clk); fd_wr = 1; fd_wdata = v;
    @(negedge clk); fd_wr = 0;
    m_fd = v & 32'hFFFF_FFF0;
  endtask

  task automatic write_br(input logic [31:0] v);
    @(negedge clk); br_wr = 1; br_wdata = v;
    @(negedge clk); br_wr = 0;
    m_br = v & 32'hFFFF_FFF3;
  endtask

  task automatic set_run(input bit v);
    @(negedge clk); run_wr = 1; run_val = v;
    @(negedge clk); run_wr = 0;
    m_run = v;
  endtask

  task automatic clear_counts();
    c_sof = 0; c_eof = 0; c_brs = 0; c_ber = 0; c_lfd = 0; c_xs = 0;
    req_n = 0; order_err = 0; xdone_given = 0;
  endtask

  task automatic run_frame(input logic [31:0] w0, w1, w2, w3,
                           input bit stop, input bit poke, input logic [31:0] poke_br);
    logic [31:0] addr;
    bit inwin, sok, e_brs;
    int e_req;
    addr  = m_br[0] ? {m_br[31:4], 4'b0} : m_fd;
    e_brs = m_br[0] & m_br[1];
    m_br[0] = 1'b0;
    inwin = desc_in(addr);
    if (inwin) begin
      mem[(addr - BASE) >> 2]       = w0;
      mem[((addr - BASE) >> 2) + 1] = w1;
      mem[((addr - BASE) >> 2) + 2] = w2;
      mem[((addr - BASE) >> 2) + 3] = w3;
      m_fd = w0 & 32'hFFFF_FFF0; m_src = w1; m_id = w2; m_cmd = w3; e_req = 4;
    end else begin
      m_src = 0; e_req = 0;
    end
    sok = src_good(m_src);
    clear_counts();
    exp_base = addr;
    stop_req = stop;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    if (poke && inwin) begin
      @(negedge clk); frame_start = 1; br_wr = 1; br_wdata = poke_br;
      @(negedge clk); frame_start = 0; br_wr = 0;
      m_br = poke_br & 32'hFFFF_FFF3;
    end
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    if (busy) chk("watch frame end", {31'b0, busy}, 32'h0);
    repeat (2) @(negedge clk);
    stop_req = 0;
    chk("R5 read count", 32'(req_n), 32'(e_req));
    chk("R4 branch event", 32'(c_brs), 32'(e_brs));
    chk("R4 R11 branch register", br_value, m_br);
    chk("R2 next pointer", fd_addr, m_fd);
    chk("R6 source", src_addr, m_src);
    chk("R5 frame id", frame_id, m_id);
    chk("R5 command", command, m_cmd);
    chk("R7 bus error", 32'(c_ber), sok ? 32'd0 : 32'd1);
    chk("R7 transfer start", 32'(c_xs), sok ? 32'd1 : 32'd0);
    chk("R8 sof", 32'(c_sof), 32'(sok & m_cmd[22]));
    chk("R8 eof", 32'(c_eof), 32'(sok & m_cmd[21]));
    chk("R8 event order", 32'(order_err), 32'd0);
    chk("R9 last frame done", 32'(c_lfd), 32'(stop));
    if (stop) m_run = 0;
    chk("R9 running", 32'(running), 32'(m_run));
  endtask

  task automatic idle_start_check(input string tag);
    clear_counts();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    repeat (3) @(negedge clk);
    chk({tag, " busy"}, 32'(busy), 32'd0);
    chk({tag, " reads"}, 32'(req_n), 32'd0);
    chk({tag, " branch kept"}, br_value, m_br);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    m_br = 0; m_fd = 0; m_src = 0; m_id = 0; m_cmd = 0; m_run = 0;
    clear_counts();
    exp_base = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 running", 32'(running), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req valid", 32'(mem_req_valid), 0);
    chk("R1 events", {27'b0, sof_evt, eof_evt, brs_evt, ber_evt, lfd_evt}, 0);
    chk("R1 branch", br_value, 0);
    chk("R1 pointer", fd_addr, 0);
    chk("R1 source", src_addr, 0);
    chk("R1 id/cmd", frame_id | command, 0);

    // R2 / R3 masking
    write_fd(BASE + 32'h123);
    chk("R2 pointer write mask", fd_addr, BASE + 32'h120);
    write_br(32'hFFFF_FFFF);
    chk("R3 branch write mask", br_value, 32'hFFFF_FFF3);
    write_br(32'h0);

    // R10 ignored while stopped
    idle_start_check("R10 stopped");
    set_run(1);

    // directed frames
    run_frame(BASE + 32'h205, BASE + 32'h800, 32'hA5A5_0001, 32'h0060_0100, 0, 0, 0);
    run_frame(BASE + 32'h300, BASE + 32'h804, 32'hA5A5_0002, 32'h0000_0040, 0, 0, 0);
    write_br(BASE + 32'h400 + 32'h3);            // R4 branch with interrupt
    run_frame(BASE + 32'h500, BASE + 32'h10, 32'h1, 32'h0020_0000, 0, 0, 0);
    write_br(BASE + 32'h600 + 32'h1);            // R4 branch without interrupt
    run_frame(BASE + 32'h700, BASE + 32'h20, 32'h2, 32'h0040_0000, 0, 0, 0);
    write_fd(BASE + SIZE[31:0] - 32'd16);         // R6 last slot inside
    run_frame(BASE, BASE + SIZE[31:0] - 32'd4, 32'h3, 32'h0060_0000, 0, 0, 0);
    write_fd(BASE + SIZE[31:0]);                  // R6 first slot outside
    run_frame(0, 0, 0, 0, 0, 0, 0);
    write_fd(BASE - 32'd16);                      // R6 below window
    run_frame(0, 0, 0, 0, 0, 0, 0);
    write_fd(BASE + 32'h40);                      // R7 zero source
    run_frame(BASE + 32'h80, 32'h0, 32'h4, 32'h0060_0000, 0, 0, 0);
    run_frame(BASE + 32'hC0, BASE + SIZE[31:0], 32'h5, 32'h0060_0000, 0, 0, 0);  // R7 source at top
    // R11 / R10 branch write and restart during a fetch
    run_frame(BASE + 32'h100, BASE + 32'h44, 32'h6, 32'h0060_0000, 0, 1, BASE + 32'h900 + 32'h3);
    run_frame(BASE + 32'h140, BASE + 32'h48, 32'h7, 32'h0060_0000, 0, 0, 0);
    // R9 stop at frame end, then R10 ignored
    run_frame(BASE + 32'h180, BASE + 32'h4C, 32'h8, 32'h0020_0000, 1, 0, 0);
    idle_start_check("R10 after stop");
    set_run(1);

    // random frames
    for (int f = 0; f < 300; f++) begin
      int r = $urandom % 10;
      if (r == 0) write_fd(rnd_addr(20));
      else if (r == 1) write_br($urandom & 32'hFFFF_000F | (rnd_addr(15) & 32'hFFFF_FFF0));
      run_frame(rnd_addr(10), rnd_src(), $urandom, $urandom, ($urandom % 20) == 0,
                ($urandom % 8) == 0, rnd_addr(10) | ($urandom % 4));
      if (!m_run) begin
        if (($urandom % 2) == 0) idle_start_check("R10 random stopped");
        set_run(1);
      end
    end

    summary();
    $finish;
  end
endmodule